// File: doc/BRIEF.md
# Four-Way Set-Associative Unified Cache

This block is an 8 KB cache that holds both instructions and data for a processor core. It has four ways, 128 sets and lines of four 32-bit doublewords. The processor side offers one request at a time, either a read or a write, with a physical address and a per-page "do not cache" attribute. A cacheable read that hits returns its doubleword in the next cycle. A read that misses asks a line-fill engine for the whole line, and the fill engine returns four doublewords in ascending word order. The line is kept only if the system marks the fill cacheable on the final beat.

Writes use a write-through policy. Every write is handed to the bus side in the next cycle. A write that hits also updates the cached copy, and a write that misses never allocates a line. Reads bypass the cache and make a single-doubleword bus read under two conditions: a global disable input is high, or the page attribute marks the access uncacheable. For coherence, the block accepts a flush that drops every line, and a snoop that invalidates the one line matching an external address while another master owns the address bus.

Top module: `ucache4w`

## Requirements
- R1: The address is split into three fields: bits 3:2 select the doubleword, bits 10:4 select one of 128 sets, and bits 31:11 form the tag. After reset every line is invalid, `req_ready_o` is 1, and `rsp_valid_o`, `fill_req_o` and `wr_valid_o` are 0.
- R2: A read hit is a read with `cache_off_i`=0 and `req_page_nc_i`=0 that matches a valid line. It drives `rsp_valid_o` high with the addressed doubleword in the cycle after acceptance, and it raises no fill request.
- R3: A cacheable read miss holds `fill_req_o` high with `fill_burst_o`=1 and a stable, line-aligned `fill_addr_o` (bits 3:0 zero). It takes four `fill_valid_i` beats for words 0,1,2,3 in that order. It then returns the requested word in the cycle after the last beat.
- R4: A filled line becomes valid only if `fill_ken_ni` is 0 on the last beat. Otherwise a repeat of the same read misses again.
- R5: Victim choice takes the lowest-numbered invalid way first. If all four ways are valid, it uses a 3-bit tree per set: bit0=0 picks ways 0/1 (bit1 selects way1), and bit0=1 picks ways 2/3 (bit2 selects way3). Every hit or allocation turns the tree away from the way it touched.
- R6: Each accepted write appears on `wr_valid_o`, `wr_addr_o` (bits 1:0 zero) and `wr_data_o` in the next cycle. A write hit updates the cached word. A write miss allocates nothing.
- R7: While `cache_off_i` is 1, a read ignores the cache. It issues a single-beat request (`fill_burst_o`=0, `fill_addr_o` equal to the word address), returns that beat, and allocates nothing. Cached lines are still present once `cache_off_i` returns to 0.
- R8: With `req_page_nc_i`=1, a read behaves as in R7 even when `fill_ken_ni` is 0 and even when the line is cached.
- R9: A cycle with `flush_i`=1 invalidates every line.
- R10: A cycle with `snoop_strobe_i`=1 and `snoop_hold_i`=1 invalidates the line whose tag and set match `snoop_addr_i[31:4]`. A strobe with `snoop_hold_i`=0 has no effect.
- R11: A flush, or a snoop matching the line being filled, that arrives during a line fill stops that line from becoming valid. The read still returns its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Physical byte address |
| req_wdata_i | input | 32 | Write doubleword |
| req_page_nc_i | input | 1 | Page attribute: do not cache this access |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read doubleword |
| cache_off_i | input | 1 | Global cache disable |
| fill_req_o | output | 1 | Bus read request, held until the last beat |
| fill_burst_o | output | 1 | 1 = four-beat line fill, 0 = single doubleword |
| fill_addr_o | output | 32 | Line or word address of the bus read |
| fill_valid_i | input | 1 | Read beat valid |
| fill_data_i | input | 32 | Read beat data |
| fill_ken_ni | input | 1 | Active-low cacheability, sampled on the last beat |
| wr_valid_o | output | 1 | Write-through request |
| wr_addr_o | output | 32 | Write-through word address |
| wr_data_o | output | 32 | Write-through data |
| flush_i | input | 1 | Invalidate all lines |
| snoop_hold_i | input | 1 | Another master owns the address bus |
| snoop_strobe_i | input | 1 | External invalidation address strobe |
| snoop_addr_i | input | 32 | External invalidation address |

## Verification
Reads to a single set first fill all four ways, then hit one way, then force an eviction. Which of the remaining tags still hit and which one misses shows whether the victim came from the tree or from a fixed way. Repeated reads tell an allocated fill from one refused by `fill_ken_ni`. The same address is then read with the global disable and the page attribute set, and the single-beat request separates bypass from a hidden hit. Three coherence cases are compared: snoops with and without bus ownership, a snoop to another word of a cached line, and a snoop that lands in the middle of a fill.

// File: rtl/ucache_pkg.sv
package ucache_pkg;
  localparam int WAYS       = 4;   // tree replacement below is built for four ways
  localparam int WAY_W      = 2;
  localparam int WORDS      = 4;
  localparam int WORD_W     = 2;
  localparam int DATA_W     = 32;
  localparam int LINE_OFF_W = 4;

  typedef logic [2:0] plru_t;
  typedef enum logic {ST_IDLE, ST_FILL} state_e;

  function automatic logic [WAY_W-1:0] plru_pick(input plru_t t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic plru_t plru_touch(input plru_t t, input logic [WAY_W-1:0] w);
    plru_t n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/ucache_tags.sv
module ucache_tags
  import ucache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  lk_valid_o,
  output logic [WAYS-1:0]  lk_hit_o,
  input  logic             sn_en_i,
  input  logic [IDX_W-1:0] sn_idx_i,
  input  logic [TAG_W-1:0] sn_tag_i,
  input  logic             drop_en_i,
  input  logic [IDX_W-1:0] drop_idx_i,
  input  logic [WAY_W-1:0] drop_way_i,
  input  logic             alloc_en_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic [WAY_W-1:0] alloc_way_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic             flush_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  sn_hit;

  assign lk_valid_o = valid_q[lk_idx_i];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_hit_o[w] = valid_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
      sn_hit[w]   = valid_q[sn_idx_i][w] && (tag_q[sn_idx_i][w] == sn_tag_i);
    end
  end

  // later terms win: set, then drop, snoop, flush
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_d[s][w] = valid_q[s][w];
        if (alloc_en_i && alloc_idx_i == IDX_W'(s) && alloc_way_i == WAY_W'(w))
          valid_d[s][w] = 1'b1;
        if (drop_en_i && drop_idx_i == IDX_W'(s) && drop_way_i == WAY_W'(w))
          valid_d[s][w] = 1'b0;
        if (sn_en_i && sn_idx_i == IDX_W'(s) && sn_hit[w])
          valid_d[s][w] = 1'b0;
        if (flush_i)
          valid_d[s][w] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_en_i) tag_q[alloc_idx_i][alloc_way_i] <= alloc_tag_i;
  end

  a_r1_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_o));

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lk_valid_o == '0));
endmodule

// File: rtl/ucache_plru.sv
module ucache_plru
  import ucache_pkg::*;
#(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  plru_t tree_q [SETS];

  always_comb begin
    victim_o = plru_pick(tree_q[rd_idx_i]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) victim_o = WAY_W'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en_i) begin
      tree_q[upd_idx_i] <= plru_touch(tree_q[upd_idx_i], upd_way_i);
    end
  end

  a_r5_invalid_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[victim_o]);
endmodule

// File: rtl/ucache_data.sv
module ucache_data
  import ucache_pkg::*;
#(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int AW    = IDX_W + WAY_W + WORD_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [2**AW];

  assign rd_data_o = mem_q[{rd_idx_i, rd_way_i, rd_word_i}];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_idx_i, wr_way_i, wr_word_i}] <= wr_data_i;
  end
endmodule

// File: rtl/ucache4w.sv
module ucache4w
  import ucache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - LINE_OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_page_nc_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  input  logic              cache_off_i,
  output logic              fill_req_o,
  output logic              fill_burst_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_ken_ni,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              flush_i,
  input  logic              snoop_hold_i,
  input  logic              snoop_strobe_i,
  input  logic [ADDR_W-1:0] snoop_addr_i
);
  localparam int LINE_W = ADDR_W - LINE_OFF_W;

  state_e            st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              nc_q, kill_q;
  logic [WAY_W-1:0]  way_q;
  logic [WORD_W-1:0] beat_q;
  logic [DATA_W-1:0] word_q;
  logic              rsp_valid_q, wr_valid_q;
  logic [DATA_W-1:0] rsp_data_q, wr_data_q;
  logic [ADDR_W-1:0] wr_addr_q;

  logic [IDX_W-1:0]  req_idx, q_idx, sn_idx;
  logic [TAG_W-1:0]  req_tag, q_tag, sn_tag;
  logic [WORD_W-1:0] req_word, q_word;
  logic [WAYS-1:0]   lk_hit, lk_valid;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [DATA_W-1:0] rd_data;
  logic accept, cacheable, any_hit, rd_hit, rd_go, wr_hit;
  logic snoop_en, kill_now, last_beat, alloc_en, beat_wr;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{req_addr_i[1:0], snoop_addr_i[LINE_OFF_W-1:0]};

  assign req_idx  = req_addr_i[LINE_OFF_W +: IDX_W];
  assign req_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_word = req_addr_i[2 +: WORD_W];
  assign q_idx    = addr_q[LINE_OFF_W +: IDX_W];
  assign q_tag    = addr_q[ADDR_W-1 -: TAG_W];
  assign q_word   = addr_q[2 +: WORD_W];
  assign sn_idx   = snoop_addr_i[LINE_OFF_W +: IDX_W];
  assign sn_tag   = snoop_addr_i[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign any_hit   = |lk_hit;
  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign cacheable = !cache_off_i && !req_page_nc_i;
  assign rd_hit    = accept && !req_write_i && cacheable && any_hit;
  assign rd_go     = accept && !req_write_i && !rd_hit;
  assign wr_hit    = accept && req_write_i && any_hit;
  assign snoop_en  = snoop_strobe_i && snoop_hold_i;

  // a flush or a snoop on the line in flight cancels its allocation
  assign kill_now  = (st_q == ST_FILL) &&
                     (flush_i || (snoop_en &&
                      snoop_addr_i[ADDR_W-1 -: LINE_W] == addr_q[ADDR_W-1 -: LINE_W]));
  assign beat_wr   = (st_q == ST_FILL) && fill_valid_i && !nc_q;
  assign last_beat = (st_q == ST_FILL) && fill_valid_i &&
                     (nc_q || beat_q == WORD_W'(WORDS - 1));
  assign alloc_en  = last_beat && !nc_q && !fill_ken_ni && !kill_q && !kill_now;

  ucache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (req_idx),
    .lk_tag_i    (req_tag),
    .lk_valid_o  (lk_valid),
    .lk_hit_o    (lk_hit),
    .sn_en_i     (snoop_en),
    .sn_idx_i    (sn_idx),
    .sn_tag_i    (sn_tag),
    .drop_en_i   (rd_go && cacheable),
    .drop_idx_i  (req_idx),
    .drop_way_i  (victim),
    .alloc_en_i  (alloc_en),
    .alloc_idx_i (q_idx),
    .alloc_way_i (way_q),
    .alloc_tag_i (q_tag),
    .flush_i     (flush_i)
  );

  ucache_plru #(.SETS(SETS)) u_plru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (req_idx),
    .valid_i   (lk_valid),
    .victim_o  (victim),
    .upd_en_i  (rd_hit || wr_hit || alloc_en),
    .upd_idx_i (alloc_en ? q_idx : req_idx),
    .upd_way_i (alloc_en ? way_q : hit_way)
  );

  ucache_data #(.SETS(SETS)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (req_idx),
    .rd_way_i  (hit_way),
    .rd_word_i (req_word),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_hit || beat_wr),
    .wr_idx_i  (wr_hit ? req_idx : q_idx),
    .wr_way_i  (wr_hit ? hit_way : way_q),
    .wr_word_i (wr_hit ? req_word : beat_q),
    .wr_data_i (wr_hit ? req_wdata_i : fill_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      nc_q        <= 1'b0;
      kill_q      <= 1'b0;
      way_q       <= '0;
      beat_q      <= '0;
      word_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      wr_valid_q  <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      wr_valid_q  <= 1'b0;
      if (rd_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_data;
      end
      if (accept && req_write_i) begin
        wr_valid_q <= 1'b1;
        wr_addr_q  <= {req_addr_i[ADDR_W-1:2], 2'b00};
        wr_data_q  <= req_wdata_i;
      end
      if (rd_go) begin
        st_q   <= ST_FILL;
        addr_q <= req_addr_i;
        nc_q   <= !cacheable;
        way_q  <= victim;
        beat_q <= '0;
        kill_q <= 1'b0;
      end
      if (st_q == ST_FILL) begin
        if (kill_now) kill_q <= 1'b1;
        if (fill_valid_i) begin
          if (beat_q == q_word) word_q <= fill_data_i;
          if (last_beat) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= (nc_q || beat_q == q_word) ? fill_data_i : word_q;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      end
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign fill_req_o   = (st_q == ST_FILL);
  assign fill_burst_o = !nc_q;
  assign fill_addr_o  = nc_q ? {addr_q[ADDR_W-1:2], 2'b00}
                             : {addr_q[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
  assign wr_valid_o   = wr_valid_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;

  a_r2_hit_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> rsp_valid_o && !fill_req_o);

  a_r7_bypass_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_write_i && !cacheable) |=> fill_req_o && !fill_burst_o);

  a_r6_write_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_write_i) |=> wr_valid_o && (wr_data_o == $past(req_wdata_i)));

  a_r3_fill_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> fill_req_o && $stable(fill_addr_o));
endmodule

// File: tb/ucache4w_bench.sv
module ucache4w_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_page_nc_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        cache_off_i = 1'b0;
  logic        fill_req_o, fill_burst_o;
  logic [31:0] fill_addr_o;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_data_i = '0;
  logic        fill_ken_ni = 1'b1;
  logic        wr_valid_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        flush_i = 1'b0, snoop_hold_i = 1'b0, snoop_strobe_i = 1'b0;
  logic [31:0] snoop_addr_i = '0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ucache4w u_ucache4w (.*);

  int checks = 0, errors = 0;
  int fills = 0, rsp_cnt = 0, wr_cnt = 0;
  bit last_burst;
  logic [31:0] last_base;
  bit ken_val = 1'b0;
  bit snoop_mid = 1'b0;
  logic [31:0] mem [logic [29:0]];
  logic [31:0] exp_rd [$];
  string       exp_rl [$];
  logic [63:0] exp_wr [$];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a[31:2])) return mem[a[31:2]];
    return (32'(a[31:2]) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] set5(input int k);
    return 32'h0010_0000 + 32'(k) * 32'h800 + 32'h50;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // fill engine model: two idle cycles before each beat
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && fill_req_o) begin
        int n;
        fills++;
        last_burst = fill_burst_o;
        last_base  = fill_addr_o;
        n = fill_burst_o ? 4 : 1;
        for (int b = 0; b < n; b++) begin
          @(negedge clk_i);
          @(negedge clk_i);
          fill_valid_i = 1'b1;
          fill_data_i  = mem_rd(last_base + 32'(4 * b));
          fill_ken_ni  = ken_val;
          if (snoop_mid && b == 1) begin
            snoop_strobe_i = 1'b1;
            snoop_hold_i   = 1'b1;
            snoop_addr_i   = last_base + 32'h8;
          end
          @(negedge clk_i);
          fill_valid_i   = 1'b0;
          fill_ken_ni    = 1'b1;
          snoop_strobe_i = 1'b0;
          snoop_hold_i   = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_valid_o) begin
        if (exp_rd.size() == 0) chk(1'b0, "R2", "unexpected response", rsp_data_o, 32'h0);
        else begin
          logic [31:0] e;
          string l;
          e = exp_rd.pop_front();
          l = exp_rl.pop_front();
          chk(rsp_data_o == e, l, "read data", rsp_data_o, e);
        end
        rsp_cnt++;
      end
      if (wr_valid_o) begin
        if (exp_wr.size() == 0) chk(1'b0, "R6", "unexpected write", wr_addr_o, 32'h0);
        else begin
          logic [63:0] e;
          e = exp_wr.pop_front();
          chk(wr_addr_o == e[63:32], "R6", "write-through address", wr_addr_o, e[63:32]);
          chk(wr_data_o == e[31:0], "R6", "write-through data", wr_data_o, e[31:0]);
        end
        mem[wr_addr_o[31:2]] = wr_data_o;
        wr_cnt++;
      end
    end
  end

  task automatic do_read(input logic [31:0] a, input bit nc, input int exp_fill,
                         input bit exp_burst, input string req);
    int f0, c0;
    logic [31:0] eb;
    exp_rd.push_back(mem_rd(a));
    exp_rl.push_back(req);
    f0 = fills;
    c0 = rsp_cnt;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a; req_page_nc_i = nc;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_page_nc_i = 1'b0;
    while (rsp_cnt == c0) @(negedge clk_i);
    chk(fills - f0 == exp_fill, req, "bus read count", 32'(fills - f0), 32'(exp_fill));
    if (exp_fill == 1 && fills - f0 == 1) begin
      eb = exp_burst ? {a[31:4], 4'h0} : {a[31:2], 2'b00};
      chk(last_burst == exp_burst, req, "burst flag", 32'(last_burst), 32'(exp_burst));
      chk(last_base == eb, req, "bus read address", last_base, eb);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int c0;
    exp_wr.push_back({a[31:2], 2'b00, d});
    c0 = wr_cnt;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    while (wr_cnt == c0) @(negedge clk_i);
  endtask

  task automatic pulse_snoop(input logic [31:0] a, input bit hold);
    @(negedge clk_i);
    snoop_strobe_i = 1'b1; snoop_hold_i = hold; snoop_addr_i = a;
    @(negedge clk_i);
    snoop_strobe_i = 1'b0; snoop_hold_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 32'(req_ready_o), 32'h1);
    chk(!rsp_valid_o && !fill_req_o && !wr_valid_o, "R1", "outputs idle in reset",
        32'({rsp_valid_o, fill_req_o, wr_valid_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 miss, then R2 hits on two words of the line
    do_read(set5(0) + 32'h4, 1'b0, 1, 1'b1, "R3");
    do_read(set5(0) + 32'h4, 1'b0, 0, 1'b1, "R2");
    do_read(set5(0) + 32'hC, 1'b0, 0, 1'b1, "R2");

    // R6 write hit updates, write miss does not allocate
    do_write(set5(0) + 32'h8, 32'hCAFE_0001);
    do_read(set5(0) + 32'h8, 1'b0, 0, 1'b1, "R6");
    do_write(32'h0020_0234, 32'hBEEF_0002);
    do_read(32'h0020_0234, 1'b0, 1, 1'b1, "R6");

    // R5 replacement in set 5
    do_read(set5(1), 1'b0, 1, 1'b1, "R5");
    do_read(set5(2), 1'b0, 1, 1'b1, "R5");
    do_read(set5(3), 1'b0, 1, 1'b1, "R5");
    do_read(set5(0), 1'b0, 0, 1'b1, "R5");
    do_read(set5(4), 1'b0, 1, 1'b1, "R5");
    do_read(set5(0), 1'b0, 0, 1'b1, "R5");
    do_read(set5(1), 1'b0, 0, 1'b1, "R5");
    do_read(set5(3), 1'b0, 0, 1'b1, "R5");
    do_read(set5(2), 1'b0, 1, 1'b1, "R5");
    do_read(set5(4), 1'b0, 0, 1'b1, "R5");

    // R4 cacheability on the last beat
    ken_val = 1'b1;
    do_read(32'h0030_0300, 1'b0, 1, 1'b1, "R4");
    ken_val = 1'b0;
    do_read(32'h0030_0300, 1'b0, 1, 1'b1, "R4");
    do_read(32'h0030_0304, 1'b0, 0, 1'b1, "R4");

    // R8 page attribute bypass
    do_read(set5(2), 1'b1, 1, 1'b0, "R8");
    do_read(32'h0040_0418, 1'b1, 1, 1'b0, "R8");
    do_read(32'h0040_0418, 1'b0, 1, 1'b1, "R8");

    // R7 global disable
    cache_off_i = 1'b1;
    do_read(32'h0030_0308, 1'b0, 1, 1'b0, "R7");
    do_read(32'h0030_0308, 1'b0, 1, 1'b0, "R7");
    cache_off_i = 1'b0;
    do_read(32'h0030_0308, 1'b0, 0, 1'b1, "R7");

    // R10 snoop needs bus ownership
    pulse_snoop(32'h0030_0300, 1'b0);
    do_read(32'h0030_0300, 1'b0, 0, 1'b1, "R10");
    pulse_snoop(32'h0030_0308, 1'b1);
    do_read(32'h0030_0300, 1'b0, 1, 1'b1, "R10");

    // R9 flush
    do_read(set5(1), 1'b0, 0, 1'b1, "R9");
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    do_read(set5(1), 1'b0, 1, 1'b1, "R9");
    do_read(32'h0030_0300, 1'b0, 1, 1'b1, "R9");

    // R11 snoop on the line in flight
    snoop_mid = 1'b1;
    do_read(32'h0050_0520, 1'b0, 1, 1'b1, "R11");
    snoop_mid = 1'b0;
    do_read(32'h0050_0524, 1'b0, 1, 1'b1, "R11");
    do_read(32'h0050_0528, 1'b0, 0, 1'b1, "R11");

    repeat (4) @(negedge clk_i);
    chk(exp_rd.size() == 0, "R2", "responses outstanding", 32'(exp_rd.size()), 32'h0);
    chk(exp_wr.size() == 0, "R6", "writes outstanding", 32'(exp_wr.size()), 32'h0);
    finish_run();
  end
endmodule